// File: doc/BRIEF.md
# Octet-Parallel Header Check Cell Delineator

The block locates cell boundaries in a byte-wide receive stream whose alignment to the byte lanes is unknown. A cell is 53 octets: a 4-octet header, one octet of header check, and 48 octets of payload. The header check is the CRC of the 32 header bits over the generator x^8 + x^2 + x + 1, with the header multiplied by x^8 before division and the constant 0x55 XORed onto the result. Because a cell may begin at any bit, every accepted octet is examined at all eight bit positions. The block carries one 8-bit remainder across octets and slides it one bit at a time, adding the newest bit and removing the bit that has just left a 40-bit window. The removal uses the fixed residue of x^40 modulo the generator, 0x62.

Each accepted octet produces a registered 8-bit vector with one flag per bit position. On top of the vector sits a hunt / pre-sync / sync machine. It locks onto the lane of the first match. It then examines only that lane, once per cell length of accepted octets, and declares or drops alignment according to runs of correct and incorrect header checks.

Top module: `hec_delineator`

## Requirements
- R1: Octets arrive first bit in bit 7, last bit in bit 0. match_vec[i] is set when the 40-bit window ending at the i-th transmitted bit of the octet (i = 0 for bit 7, i = 7 for bit 0) is a valid header. A window is valid when the CRC of its first 32 bits (times x^8, modulo x^8 + x^2 + x + 1), XOR 0x55, equals its last 8 bits, first-sent bit as MSB.
- R2: match_valid is high in the cycle after an octet is accepted (in_valid high at a rising edge) and low otherwise. match_vec is all zero whenever match_valid is low.
- R3: A window that reaches back before the first bit accepted since reset is never flagged. With 8 bits per octet, the first four octets flag nothing, and only lane 7 of the fifth octet can be flagged.
- R4: Cycles with in_valid low are ignored: the data on in_octet is not used, the bit stream continues as if the octets had arrived back to back, and sync_state and lock_offset hold.
- R5: After reset, sync_state is 0 (hunt), lock_offset is 0, match_valid is low and match_vec is 0. sync_state encodes 0 = hunt, 1 = pre-sync, 2 = sync, and never takes the value 3.
- R6: In hunt, an accepted octet with a flagged lane moves sync_state to 1 and lock_offset to that lane, both visible in the cycle after the octet.
- R7: Once out of hunt, lock_offset does not change. Only lane lock_offset is checked, and only in every 53rd accepted octet after the locking octet.
- R8: In pre-sync, an incorrect check returns sync_state to 0. The 6th consecutive correct check after the locking match moves it to 2.
- R9: In sync, a correct check clears the run of misses. Six consecutive incorrect checks keep sync_state at 2, and the 7th returns it to 0.
- R10: sync_state never goes from 0 to 2 in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | in_octet carries the next stream octet |
| in_octet | input | 8 | Stream octet, first-sent bit in bit 7 |
| match_valid | output | 1 | match_vec holds the result for the last accepted octet |
| match_vec | output | 8 | Per-lane valid-header flags |
| sync_state | output | 2 | 0 hunt, 1 pre-sync, 2 sync |
| lock_offset | output | 3 | Lane of the header check the machine follows |

## Verification
The hardest situation to reach is a long, exact run of the alignment machine. This means a lock, six good checks, six and then seven misses with a good check between the runs, and a fresh lock that fails at once. None of it may be disturbed by a chance header match at some other bit position. The bench builds this stream from a repeated header with an all-zero payload, and flips a check bit in the cells that must miss. It then scans every bit position of the stream with its own CRC and redraws the header until the only valid windows are the intended ones, so every state transition falls on a known octet. A separate short stream, whose last 32 bits form a header that is valid only when the reset zeros are counted, exercises the fill rule.

// File: rtl/hec_delineator.sv
module hec_delineator #(
  parameter int CELL_OCTETS  = 53,
  parameter int PRESYNC_GOOD = 6,
  parameter int SYNC_BAD     = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_octet,
  output logic       match_valid,
  output logic [7:0] match_vec,
  output logic [1:0] sync_state,
  output logic [2:0] lock_offset
);
  localparam int WIN   = 40;
  localparam int CNT_W = $clog2(CELL_OCTETS);
  localparam int RUN_MAX = (PRESYNC_GOOD > SYNC_BAD) ? PRESYNC_GOOD : SYNC_BAD;
  localparam int RUN_W = $clog2(RUN_MAX + 1);
  localparam logic [7:0] GEN_LOW  = 8'h07;
  localparam logic [7:0] LEAVE    = 8'h62;
  localparam logic [7:0] COSET    = 8'h55;

  typedef enum logic [1:0] {ST_HUNT = 2'd0, ST_PRE = 2'd1, ST_SYNC = 2'd2} st_t;

  logic [WIN-1:0]   hist_q;
  logic [7:0]       rem_q;
  logic [2:0]       fill_q;
  logic [8:0][7:0]  chain;
  logic [7:0]       lane_hit;
  logic [2:0]       first_lane;
  st_t              st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [RUN_W-1:0] run_q;
  logic             due, hit;

  always_comb begin
    chain[0] = rem_q;
    for (int i = 0; i < 8; i++) begin
      chain[i+1] = {chain[i][6:0], in_octet[7-i]}
                 ^ (chain[i][7] ? GEN_LOW : 8'h00)
                 ^ (hist_q[WIN-1-i] ? LEAVE : 8'h00);
    end
  end

  always_comb begin
    for (int i = 0; i < 8; i++)
      lane_hit[i] = (chain[i+1] == COSET) && ((int'(fill_q) * 8 + i + 1) >= WIN);
  end

  always_comb begin
    first_lane = '0;
    for (int i = 7; i >= 0; i--)
      if (lane_hit[i]) first_lane = 3'(i);
  end

  assign due = in_valid && (st_q != ST_HUNT) && (cnt_q == '0);
  assign hit = lane_hit[lock_offset];
  assign sync_state = st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q      <= '0;
      rem_q       <= '0;
      fill_q      <= '0;
      match_valid <= 1'b0;
      match_vec   <= '0;
    end else begin
      match_valid <= in_valid;
      match_vec   <= in_valid ? lane_hit : 8'h00;
      if (in_valid) begin
        hist_q <= {hist_q[WIN-9:0], in_octet};
        rem_q  <= chain[8];
        if (fill_q < 3'd5) fill_q <= fill_q + 3'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_HUNT;
      lock_offset <= '0;
      cnt_q       <= '0;
      run_q       <= '0;
    end else if (in_valid) begin
      if (st_q == ST_HUNT) begin
        if (|lane_hit) begin
          st_q        <= ST_PRE;
          lock_offset <= first_lane;
          cnt_q       <= CNT_W'(CELL_OCTETS - 1);
          run_q       <= '0;
        end
      end else if (!due) begin
        cnt_q <= cnt_q - 1'b1;
      end else begin
        cnt_q <= CNT_W'(CELL_OCTETS - 1);
        if (st_q == ST_PRE) begin
          if (!hit) begin
            st_q <= ST_HUNT;
          end else if (run_q == RUN_W'(PRESYNC_GOOD - 1)) begin
            st_q  <= ST_SYNC;
            run_q <= '0;
          end else begin
            run_q <= run_q + 1'b1;
          end
        end else begin
          if (hit) begin
            run_q <= '0;
          end else if (run_q == RUN_W'(SYNC_BAD - 1)) begin
            st_q  <= ST_HUNT;
            run_q <= '0;
          end else begin
            run_q <= run_q + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/hec_delineator_chk.sv
module hec_delineator_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       match_valid,
  input logic [7:0] match_vec,
  input logic [1:0] sync_state,
  input logic [2:0] lock_offset
);
  logic [2:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else if (in_valid && seen_q != 3'd7) seen_q <= seen_q + 3'd1;
  end

  p_valid_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> match_valid);
  p_valid_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !match_valid);
  p_vec_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !match_valid |-> match_vec == 8'h00);
  p_fill_early_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && seen_q < 3'd4) |=> match_vec == 8'h00);
  p_fill_fifth_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && seen_q == 3'd4) |=> match_vec[6:0] == 7'h00);
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(sync_state) && $stable(lock_offset)));
  p_legal_state_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sync_state != 2'd3);
  p_lock_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_state != 2'd0) |=> $stable(lock_offset));
  p_no_skip_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_state == 2'd0) |=> (sync_state != 2'd2));
endmodule

bind hec_delineator hec_delineator_chk i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .match_valid(match_valid),
  .match_vec(match_vec), .sync_state(sync_state), .lock_offset(lock_offset)
);

// File: tb/test_hec_delineator.sv
module test_hec_delineator;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [7:0] in_octet;
  logic       match_valid;
  logic [7:0] match_vec;
  logic [1:0] sync_state;
  logic [2:0] lock_offset;

  always #10 clk = ~clk;

  hec_delineator i_hec_delineator (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_octet(in_octet),
    .match_valid(match_valid), .match_vec(match_vec),
    .sync_state(sync_state), .lock_offset(lock_offset)
  );

  int errors = 0;
  int checks = 0;
  bit [7:0] expq[$];
  bit bs [0:16383];
  int nb;
  bit idle_mix;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit [7:0] hec_of(input bit [31:0] hd);
    bit [7:0] r;
    bit fb;
    r = 8'h00;
    for (int k = 31; k >= 0; k--) begin
      fb = r[7] ^ hd[k];
      r = {r[6:0], 1'b0};
      if (fb) r = r ^ 8'h07;
    end
    return r ^ 8'h55;
  endfunction

  function automatic bit win_ok(input int e);
    bit [31:0] hd;
    bit [7:0] tl;
    for (int k = 0; k < 32; k++) hd = {hd[30:0], bs[e-39+k]};
    for (int k = 0; k < 8; k++) tl = {tl[6:0], bs[e-7+k]};
    return hec_of(hd) == tl;
  endfunction

  task automatic put_bits(input bit [31:0] v, input int w);
    for (int k = w - 1; k >= 0; k--) begin
      bs[nb] = v[k];
      nb++;
    end
  endtask

  task automatic put_cell(input bit [31:0] hd, input bit bad, input bit rnd);
    put_bits(hd, 32);
    put_bits({24'h0, hec_of(hd) ^ (bad ? 8'h01 : 8'h00)}, 8);
    for (int k = 0; k < 48; k++) put_bits(rnd ? $urandom : 0, 8);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    in_octet = 8'($urandom);
  endtask

  task automatic send_octet(input int o);
    bit [7:0] v;
    bit [7:0] e;
    for (int i = 0; i < 8; i++) begin
      v[7-i] = bs[o*8+i];
      e[i] = (o*8 + i >= 39) && win_ok(o*8 + i);
    end
    if (idle_mix && ($urandom % 4 == 0)) idle();
    @(negedge clk);
    in_valid = 1'b1;
    in_octet = v;
    expq.push_back(e);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_octet = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expq.delete();
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (match_valid) begin
        if (expq.size() == 0) chk(1'b0, "R2 unexpected result", match_vec, 0);
        else begin
          bit [7:0] e;
          e = expq.pop_front();
          chk(match_vec == e, "R1 R3 R4 lane flags", match_vec, e);
        end
      end else if (match_vec != 8'h00) begin
        chk(1'b0, "R2 vector while not valid", match_vec, 0);
      end
    end
  end

  initial begin
    #4000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  int st_exp [0:22];
  bit bad_c  [0:22];

  initial begin
    bit [31:0] hd;
    int pre, k, c, tries;
    bit clean;
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_octet = 8'h00;
    idle_mix = 1'b0;
    do_reset();
    @(negedge clk);
    chk(sync_state == 2'd0, "R5 state after reset", sync_state, 0);
    chk(lock_offset == 3'd0, "R5 lock after reset", lock_offset, 0);
    chk(match_valid == 1'b0 && match_vec == 8'h00, "R5 outputs after reset", match_vec, 0);

    // R3: four octets that form a valid header only if reset zeros counted
    hd = {8'h00, 24'($urandom)};
    nb = 0;
    put_bits(hd, 24);
    put_bits({24'h0, hec_of(hd)}, 8);
    for (int o = 0; o < 4; o++) send_octet(o);
    idle();
    chk(match_vec == 8'h00, "R3 partial window flagged", match_vec, 0);
    chk(sync_state == 2'd0, "R3 no lock from partial window", sync_state, 0);
    idle();

    // R1 R4: random stream, two alignments, idle cycles mixed in
    do_reset();
    nb = 0;
    put_bits($urandom, 13 + $urandom % 8);
    for (int n = 0; n < 3; n++) put_cell($urandom, 1'b0, 1'b1);
    put_bits($urandom, 1 + $urandom % 11);
    for (int n = 0; n < 3; n++) put_cell($urandom, 1'b0, 1'b1);
    put_bits($urandom, 16);
    idle_mix = 1'b1;
    for (int o = 0; o < nb / 8; o++) send_octet(o);
    idle();
    idle();
    chk(expq.size() == 0, "R2 results outstanding", expq.size(), 0);

    // R6-R9: controlled run of the alignment machine
    for (int n = 0; n < 23; n++) bad_c[n] = 1'b0;
    for (int n = 7; n <= 12; n++) bad_c[n] = 1'b1;
    for (int n = 14; n <= 20; n++) bad_c[n] = 1'b1;
    bad_c[22] = 1'b1;
    for (int n = 0; n < 6; n++) st_exp[n] = 1;
    for (int n = 6; n < 20; n++) st_exp[n] = 2;
    st_exp[20] = 0;
    st_exp[21] = 1;
    st_exp[22] = 0;
    pre = 16 + $urandom % 8;
    tries = 0;
    do begin
      hd = $urandom;
      nb = 0;
      put_bits(0, pre);
      for (int n = 0; n < 23; n++) put_cell(hd, bad_c[n], 1'b0);
      put_bits(0, 32);
      put_bits(0, 32);
      clean = 1'b1;
      for (int e = 39; e < nb && clean; e++) begin
        bit want;
        want = 1'b0;
        if (e >= pre + 39 && (e - pre - 39) % 424 == 0 && (e - pre - 39) / 424 < 23)
          want = !bad_c[(e - pre - 39) / 424];
        if (win_ok(e) != want) clean = 1'b0;
      end
      tries++;
    end while (!clean && tries < 50);
    chk(clean, "R1 stream construction", tries, 0);
    k = (pre + 39) % 8;
    do_reset();
    c = 0;
    for (int o = 0; o < nb / 8; o++) begin
      send_octet(o);
      if (c < 23 && o == (pre + c * 424 + 39) / 8) begin
        idle();
        if (c == 0)
          chk(sync_state == 2'd1, "R6 lock on first match", sync_state, 1);
        else if (c <= 6)
          chk(sync_state == 2'(st_exp[c]), "R8 pre-sync run", sync_state, st_exp[c]);
        else if (c == 21)
          chk(sync_state == 2'(st_exp[c]), "R6 relock after hunt", sync_state, st_exp[c]);
        else if (c == 22)
          chk(sync_state == 2'(st_exp[c]), "R8 miss in pre-sync", sync_state, st_exp[c]);
        else
          chk(sync_state == 2'(st_exp[c]), "R9 miss run in sync", sync_state, st_exp[c]);
        if (st_exp[c] != 0)
          chk(lock_offset == 3'(k), "R7 locked lane", lock_offset, k);
        c++;
      end
    end
    idle();
    idle();
    chk(c == 23, "R7 all cell checks reached", c, 23);
    chk(expq.size() == 0, "R2 results outstanding", expq.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule